// File: doc/BRIEF.md
# Packed String Compare Unit

This block compares two 128-bit vectors, each holding a piece of a zero-terminated string, in a single combinational pass. A registered output stage can be turned on or off by a parameter. A three-bit control field selects the element size and the aggregation mode. The element size is either bytes (sixteen elements) or little-endian 16-bit words (eight elements). The aggregation mode is one of four: match against a set, match against ranges, element-by-element inequality, or substring search.

Each operand's valid length is the position of its first all-zero element. The unit compares every element of operand B against every element of operand A in one grid of byte comparators. Each comparator reports both equal and less-than, and pairs of byte comparators merge into word comparators. The unit then folds the grid into a per-element result mask and reports the index of the lowest set bit. Surrounding logic uses it as the inner step of string scanning loops: length, character class search, compare and substring find.

Top module: `psc_unit`

## Requirements
- R1: `ctrl_i[0]` set selects 16-bit word elements and clear selects byte elements. `ctrl_i[2:1]` picks the mode: 0 set-match, 1 range, 2 equal-each, 3 ordered.
- R2: In word mode, element k is bytes 2k (low) and 2k+1 (high), compared as an unsigned 16-bit value. Only mask bits 7:0 can be set, and a word with just one zero byte is not a terminator.
- R3: An operand's valid length is the index of its first zero element, or the element count if it has none. `a_term_o` and `b_term_o` are 1 exactly when that operand holds a zero element.
- R4: Set-match sets bit i when B element i equals any element of A below A's valid length.
- R5: Range mode reads A elements (0,1), (2,3) and so on as inclusive unsigned lower and upper bounds. It uses only pairs that lie entirely below A's valid length, and sets bit i when B element i falls inside any such pair.
- R6: Equal-each sets bit i when A and B differ at element i. Bits at or beyond the shorter of the two valid lengths are cleared.
- R7: Ordered mode sets bit i when every valid A element j matches B element i+j. Positions i+j at or past B's valid length count as matches, so an empty A matches every valid position.
- R8: `found_o` is 1 when any mask bit is set, and `idx_o` is then the lowest set bit position.
- R9: With no mask bit set, `found_o` is 0 and `idx_o` equals the element count (16 for bytes, 8 for words).
- R10: With the output register enabled (default), outputs follow the inputs one clock later. A synchronous reset drives every output to zero.
- R11: In set-match, range and ordered modes, no mask bit at or beyond B's valid length is set. Element contents after a terminator never change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 3 | Element size (bit 0) and aggregation mode (bits 2:1) |
| opa_i | input | 128 | Operand A, element 0 in the low bits |
| opb_i | input | 128 | Operand B, element 0 in the low bits |
| mask_o | output | 16 | Per-element result mask |
| idx_o | output | 5 | Lowest set mask position, or element count |
| found_o | output | 1 | Any mask bit set |
| a_term_o | output | 1 | Operand A contains a terminator |
| b_term_o | output | 1 | Operand B contains a terminator |

## Verification
Terminator masking and comparator results act on the same element in the same cycle. Where the two meet, the outcome hangs on which one takes precedence. Vectors place a difference exactly on, and just after, a terminator: differing bytes past a zero in equal-each mode, and a lone range bound left unpaired by the length. A match that runs off the end of B in ordered mode is another such vector. Each is judged by the mask and index against values worked out from the requirements. A full-width case with no terminator and a difference in the last element checks the other extreme.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int NB = 16;                // byte lanes per operand
    localparam int LW = $clog2(NB) + 1;    // width of a length or index

    typedef enum logic [1:0] {
        AGG_ANY   = 2'd0,
        AGG_RANGE = 2'd1,
        AGG_EACH  = 2'd2,
        AGG_ORDER = 2'd3
    } agg_e;

    // Packed: agg occupies bits [2:1], word bit [0].
    typedef struct packed {
        agg_e agg;
        logic word;
    } ctrl_t;

    function automatic int elem_cnt(input int nb, input logic word);
        return word ? nb / 2 : nb;
    endfunction

endpackage

// File: rtl/psc_byte_cmp.sv
module psc_byte_cmp (
    input  logic [7:0] x_i,
    input  logic [7:0] y_i,
    output logic       eq_o,
    output logic       lt_o
);
    // One ordering comparator: x == y and x < y, unsigned.
    assign eq_o = (x_i == y_i);
    assign lt_o = (x_i <  y_i);
endmodule

// File: rtl/psc_cmp_grid.sv
module psc_cmp_grid #(
    parameter int NB = psc_pkg::NB
) (
    input  logic                   word_i,
    input  logic [8*NB-1:0]        a_i,
    input  logic [8*NB-1:0]        b_i,
    output logic [NB-1:0][NB-1:0]  eq_o,   // [b elem][a elem]
    output logic [NB-1:0][NB-1:0]  lt_o    // b elem < a elem
);
    logic [NB-1:0][NB-1:0] beq, blt;

    // Byte comparator bank, every B lane against every A lane.
    for (genvar bi = 0; bi < NB; bi++) begin : g_b
        for (genvar aj = 0; aj < NB; aj++) begin : g_a
            psc_byte_cmp u_cmp (
                .x_i  (b_i[8*bi +: 8]),
                .y_i  (a_i[8*aj +: 8]),
                .eq_o (beq[bi][aj]),
                .lt_o (blt[bi][aj])
            );
        end
    end

    // Element view: in word mode, merge high/low byte comparators.
    for (genvar ei = 0; ei < NB; ei++) begin : g_ei
        for (genvar ej = 0; ej < NB; ej++) begin : g_ej
            if (ei < NB/2 && ej < NB/2) begin : g_pair
                logic hi_eq, hi_lt, lo_eq, lo_lt;
                assign hi_eq = beq[2*ei+1][2*ej+1];
                assign hi_lt = blt[2*ei+1][2*ej+1];
                assign lo_eq = beq[2*ei][2*ej];
                assign lo_lt = blt[2*ei][2*ej];
                assign eq_o[ei][ej] = word_i ? (hi_eq & lo_eq) : beq[ei][ej];
                assign lt_o[ei][ej] = word_i ? (hi_lt | (hi_eq & lo_lt))
                                             : blt[ei][ej];
            end else begin : g_single
                assign eq_o[ei][ej] = !word_i & beq[ei][ej];
                assign lt_o[ei][ej] = !word_i & blt[ei][ej];
            end
        end
    end
endmodule

// File: rtl/psc_len.sv
module psc_len
    import psc_pkg::*;
#(
    parameter int NB = psc_pkg::NB,
    localparam int LW = $clog2(NB) + 1
) (
    input  logic            word_i,
    input  logic [8*NB-1:0] v_i,
    output logic [LW-1:0]   len_o,
    output logic            term_o
);
    logic [NB-1:0] bz, ez;

    for (genvar k = 0; k < NB; k++) begin : g_bz
        assign bz[k] = (v_i[8*k +: 8] == 8'h00);
    end

    for (genvar k = 0; k < NB; k++) begin : g_ez
        if (k < NB/2) begin : g_lo
            assign ez[k] = word_i ? (bz[2*k] & bz[2*k+1]) : bz[k];
        end else begin : g_hi
            assign ez[k] = !word_i & bz[k];
        end
    end

    // Lowest zero element wins.
    always_comb begin
        len_o = LW'(elem_cnt(NB, word_i));
        for (int k = NB-1; k >= 0; k--) begin
            if (ez[k]) len_o = LW'(k);
        end
    end

    assign term_o = |ez;
endmodule

// File: rtl/psc_agg.sv
module psc_agg
    import psc_pkg::*;
#(
    parameter int NB = psc_pkg::NB,
    localparam int LW = $clog2(NB) + 1
) (
    input  ctrl_t                 ctl_i,
    input  logic [NB-1:0][NB-1:0] eq_i,
    input  logic [NB-1:0][NB-1:0] lt_i,
    input  logic [LW-1:0]         la_i,
    input  logic [LW-1:0]         lb_i,
    output logic [NB-1:0]         mask_o
);
    logic [LW-1:0] lim;

    always_comb begin
        lim = (ctl_i.agg == AGG_EACH && la_i < lb_i) ? la_i : lb_i;
        for (int i = 0; i < NB; i++) begin
            logic hit;
            hit = 1'b0;
            case (ctl_i.agg)
                AGG_ANY: begin
                    for (int j = 0; j < NB; j++) begin
                        if (LW'(j) < la_i && eq_i[i][j]) hit = 1'b1;
                    end
                end
                AGG_RANGE: begin
                    for (int k = 0; k < NB/2; k++) begin
                        if (LW'(2*k+1) < la_i && !lt_i[i][2*k] &&
                            (lt_i[i][2*k+1] || eq_i[i][2*k+1])) hit = 1'b1;
                    end
                end
                AGG_EACH: begin
                    hit = !eq_i[i][i];
                end
                default: begin
                    hit = 1'b1;
                    for (int j = 0; j < NB - i; j++) begin
                        if (LW'(j) < la_i && LW'(i+j) < lb_i && !eq_i[i+j][j])
                            hit = 1'b0;
                    end
                end
            endcase
            mask_o[i] = hit && (LW'(i) < lim);
        end
    end
endmodule

// File: rtl/psc_unit.sv
module psc_unit
    import psc_pkg::*;
#(
    parameter int NB = psc_pkg::NB,
    parameter bit OUT_REG = 1'b1,
    localparam int LW = $clog2(NB) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      ctrl_i,
    input  logic [8*NB-1:0] opa_i,
    input  logic [8*NB-1:0] opb_i,
    output logic [NB-1:0]   mask_o,
    output logic [LW-1:0]   idx_o,
    output logic            found_o,
    output logic            a_term_o,
    output logic            b_term_o
);
    ctrl_t                 ctl;
    logic [NB-1:0][NB-1:0] eq_g, lt_g;
    logic [LW-1:0]         la_c, lb_c, cnt_c, idx_c;
    logic                  ta_c, tb_c, found_c;
    logic [NB-1:0]         mask_c;

    assign ctl   = ctrl_t'(ctrl_i);
    assign cnt_c = LW'(elem_cnt(NB, ctl.word));

    psc_cmp_grid #(.NB(NB)) u_grid (
        .word_i (ctl.word), .a_i (opa_i), .b_i (opb_i),
        .eq_o   (eq_g),     .lt_o (lt_g)
    );

    psc_len #(.NB(NB)) u_len_a (
        .word_i (ctl.word), .v_i (opa_i), .len_o (la_c), .term_o (ta_c)
    );

    psc_len #(.NB(NB)) u_len_b (
        .word_i (ctl.word), .v_i (opb_i), .len_o (lb_c), .term_o (tb_c)
    );

    psc_agg #(.NB(NB)) u_agg (
        .ctl_i (ctl), .eq_i (eq_g), .lt_i (lt_g),
        .la_i  (la_c), .lb_i (lb_c), .mask_o (mask_c)
    );

    // Priority encoder: lowest set bit, element count when empty.
    always_comb begin
        idx_c = cnt_c;
        for (int k = NB-1; k >= 0; k--) begin
            if (mask_c[k]) idx_c = LW'(k);
        end
    end
    assign found_c = |mask_c;

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_o   <= '0;
                idx_o    <= '0;
                found_o  <= 1'b0;
                a_term_o <= 1'b0;
                b_term_o <= 1'b0;
            end else begin
                mask_o   <= mask_c;
                idx_o    <= idx_c;
                found_o  <= found_c;
                a_term_o <= ta_c;
                b_term_o <= tb_c;
            end
        end

        p_reg_follow_r10: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (mask_o == $past(mask_c) && idx_o == $past(idx_c)));
    end else begin : g_comb
        assign mask_o   = mask_c;
        assign idx_o    = idx_c;
        assign found_o  = found_c;
        assign a_term_o = ta_c;
        assign b_term_o = tb_c;
    end

    // ---------------- assertions ----------------
    logic [NB-1:0] below_c;
    logic [LW-1:0] shorter_c;
    assign below_c   = (NB'(1) << idx_c) - NB'(1);
    assign shorter_c = (la_c < lb_c) ? la_c : lb_c;

    p_idx_hit_r8: assert property (@(posedge clk) disable iff (rst)
        found_c |-> mask_c[idx_c[LW-2:0]]);

    p_idx_first_r8: assert property (@(posedge clk) disable iff (rst)
        found_c |-> ((mask_c & below_c) == '0));

    p_none_count_r9: assert property (@(posedge clk) disable iff (rst)
        !found_c |-> (idx_c == cnt_c));

    p_word_hi_r2: assert property (@(posedge clk) disable iff (rst)
        ctl.word |-> (mask_c[NB-1:NB/2] == '0));

    p_blen_r11: assert property (@(posedge clk) disable iff (rst)
        (mask_c >> lb_c) == '0);

    p_each_short_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.agg == AGG_EACH) |-> ((mask_c >> shorter_c) == '0));

    p_term_r3: assert property (@(posedge clk) disable iff (rst)
        !ta_c |-> (la_c == cnt_c));
endmodule

// File: tb/test_psc_unit.sv
`timescale 1ns/1ps
module test_psc_unit;

    typedef struct packed {
        logic [3:0]   rq;
        logic [2:0]   c;
        logic [127:0] a;
        logic [127:0] b;
        logic [15:0]  m;
        logic [4:0]   x;
        logic         f;
        logic         ta;
        logic         tb;
    } vec_t;

    localparam int NV = 15;
    localparam logic [127:0] ALL41 = 128'h41414141414141414141414141414141;

    localparam vec_t TBL [NV] = '{
        // R6: "abcd" vs "abXd", differ at 2
        '{4'd6, 3'b100, 128'h64636261, 128'h64586261, 16'h0004, 5'd2, 1'b1, 1'b1, 1'b1},
        // R6 R9: identical "abc"
        '{4'd6, 3'b100, 128'h636261, 128'h636261, 16'h0000, 5'd16, 1'b0, 1'b1, 1'b1},
        // R4: set "aeiou" over "hello"
        '{4'd4, 3'b000, 128'h756f696561, 128'h6f6c6c6568, 16'h0012, 5'd1, 1'b1, 1'b1, 1'b1},
        // R5: ranges 0-9, a-z over "!x5Q"
        '{4'd5, 3'b010, 128'h7a613930, 128'h51357821, 16'h0006, 5'd1, 1'b1, 1'b1, 1'b1},
        // R7: "lo" in "hello"
        '{4'd7, 3'b110, 128'h6f6c, 128'h6f6c6c6568, 16'h0008, 5'd3, 1'b1, 1'b1, 1'b1},
        // R7: "lox" runs off end of "hello"
        '{4'd7, 3'b110, 128'h786f6c, 128'h6f6c6c6568, 16'h0008, 5'd3, 1'b1, 1'b1, 1'b1},
        // R2 R6: word equal-each, differ at low byte of elem 1
        '{4'd2, 3'b101, 128'h56781234, 128'h56791234, 16'h0002, 5'd1, 1'b1, 1'b1, 1'b1},
        // R2 R4: word set with half-zero words
        '{4'd2, 3'b001, 128'h00ff0100, 128'h0100000100ff, 16'h0005, 5'd0, 1'b1, 1'b1, 1'b1},
        // R2 R5: word range 0x1000..0x2000
        '{4'd5, 3'b011, 128'h20001000, 128'h2001200010000fff, 16'h0006, 5'd1, 1'b1, 1'b1, 1'b1},
        // R9 R3: word, no terminators, equal
        '{4'd9, 3'b101, ALL41, ALL41, 16'h0000, 5'd8, 1'b0, 1'b0, 1'b0},
        // R6 R3: byte, no terminators, differ in last elem
        '{4'd6, 3'b100, ALL41, 128'h42414141414141414141414141414141, 16'h8000, 5'd15, 1'b1, 1'b0, 1'b0},
        // R4 R9: empty A
        '{4'd4, 3'b000, 128'h0, 128'h6261, 16'h0000, 5'd16, 1'b0, 1'b1, 1'b1},
        // R11 R5: unpaired trailing bound ignored
        '{4'd11, 3'b010, 128'h307a61, 128'h35, 16'h0000, 5'd16, 1'b0, 1'b1, 1'b1},
        // R11 R6: bytes after terminator differ
        '{4'd11, 3'b100, 128'h5a006261, 128'h51006261, 16'h0000, 5'd16, 1'b0, 1'b1, 1'b1},
        // R7: empty A matches every valid position of "abc"
        '{4'd7, 3'b110, 128'h0, 128'h636261, 16'h0007, 5'd0, 1'b1, 1'b1, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   ctrl = 3'b000;
    logic [127:0] opa = ALL41;
    logic [127:0] opb = ALL41;
    logic [15:0]  mask;
    logic [4:0]   idx;
    logic         found, a_term, b_term;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    psc_unit i_psc_unit (
        .clk (clk), .rst (rst), .ctrl_i (ctrl), .opa_i (opa), .opb_i (opb),
        .mask_o (mask), .idx_o (idx), .found_o (found),
        .a_term_o (a_term), .b_term_o (b_term)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 reset mask",  32'(mask),  32'h0);
        chk("R10 reset idx",   32'(idx),   32'h0);
        chk("R10 reset found", 32'(found), 32'h0);
        chk("R10 reset terms", 32'({a_term, b_term}), 32'h0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            ctrl = TBL[v].c;
            opa  = TBL[v].a;
            opb  = TBL[v].b;
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d mask", TBL[v].rq, v),  32'(mask),  32'(TBL[v].m));
            chk($sformatf("R8 vec%0d idx", v),               32'(idx),   32'(TBL[v].x));
            chk($sformatf("R8 vec%0d found", v),             32'(found), 32'(TBL[v].f));
            chk($sformatf("R3 vec%0d a_term", v),            32'(a_term), 32'(TBL[v].ta));
            chk($sformatf("R3 vec%0d b_term", v),            32'(b_term), 32'(TBL[v].tb));
        end

        // R10: outputs hold until the next edge, then follow
        ctrl = TBL[0].c;
        opa  = TBL[0].a;
        opb  = TBL[0].b;
        #1;
        chk("R10 hold before edge", 32'(mask), 32'h0007);
        @(posedge clk);
        @(negedge clk);
        chk("R10 update after edge", 32'(mask), 32'h0004);

        // R1: same data, mode switched from equal-each to set-match
        ctrl = 3'b000;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mode select mask", 32'(mask), 32'h000b);

        // R10: synchronous reset mid-run clears outputs
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 midrun reset mask",  32'(mask),  32'h0);
        chk("R10 midrun reset found", 32'(found), 32'h0);
        rst = 1'b0;

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule